// File: doc/BRIEF.md
# Dual-Source Programmable Clock Output Bank

This block drives three independent clock output pins. Each pin has its own 8-bit control register. The register picks one of two reference clocks: a slow 32768 Hz reference or a fast 4 MHz reference. On the fast path the selected clock first passes a pre-divider with a fixed ratio table. On either path it then passes a power-of-two post-divider. An enable bit gates the result. Software programs the registers through a simple write/read port at three consecutive addresses.

Both reference clocks are sampled in a fast core clock domain. Each sampled reference edge becomes a half-period event. Both divide stages count these events, so every ratio gives a 50% duty output. Each output pin is driven straight from a core-domain register, so no combinational glitch can reach it. The core clock must run at least four times faster than the fast reference.

Top module: `clkout_bank`

## Requirements
- R1: The control registers of outputs 0, 1 and 2 sit at addresses 0, 1 and 2 and read back what was written. A write to address 3 changes no register, and a read of address 3 returns 0.
- R2: Bit 0 of a control register enables its output. While the enable is clear, the output is held low.
- R3: Bits [3:1] hold a post-divider code n, which divides the selected clock by 2^n. Code 0 passes the clock through undivided.
- R4: Bit 4 selects the source. A value of 0 selects the slow reference and 1 selects the fast reference.
- R5: On the fast source, bits [7:5] select the pre-divide ratio. Codes 0 to 7 map to 1, 2, 4, 8, 16, 32, 64 and 122. The output period is the fast period times the pre ratio times 2^n.
- R6: On the slow source, bits [7:5] have no effect, and the output period is the slow period times 2^n.
- R7: Every setting gives a 50% duty output: the high time is exactly half the period.
- R8: The output changes state only on a divided reference event. A write that changes bits [7:1] restarts the counters, so the new period holds from the first rising edge after the write.
- R9: Enable changes take effect only while the output is low. Clearing the enable during a high phase lets that phase run to its full length.
- R10: Reset clears all three registers to 0 and drives every output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; samples references and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| ref_slow | input | 1 | Slow (32768 Hz) reference clock |
| ref_fast | input | 1 | Fast (4 MHz) reference clock |
| clk_out | output | 3 | Divided, gated clock outputs |

## Verification
The hardest case to reach from the ports is clearing the enable partway through a high phase. The high phase must run to full length and the output must then stay low. The bench waits for a rising output edge and writes the disable a few cycles later, still inside that high phase. It then counts the remaining high samples and watches the low level for hundreds of cycles. The reference clocks toggle at whole multiples of the core period, offset from the core edges. This makes every period and high time an exact cycle count. The bench starts measuring at the first rising edge after each write, which confirms that the restart gives a full new period.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  localparam int unsigned CTRL_W = 8;

  // Fast-path pre-divide ratio for a 3-bit code: powers of two, last code special.
  function automatic int unsigned pre_ratio(input logic [2:0] code, input int unsigned last);
    if (code == 3'd7) return last;
    return 32'd1 << code;
  endfunction

endpackage

// File: rtl/clkout_rstsync.sv
module clkout_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/clkout_refsync.sv
module clkout_refsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic edge_o
);

  // STAGES synchronizer flops plus one history flop.
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], ref_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // Either edge of the reference is one half-period event.
  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];

endmodule

// File: rtl/clkout_regs.sv
module clkout_regs #(
  parameter int NUM = 3,
  parameter int AW  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  output logic [NUM-1:0][7:0] ctrl_o,
  output logic [NUM-1:0]      restart_o
);

  logic [NUM-1:0][7:0] ctrl_q;
  logic [NUM-1:0][7:0] ctrl_d;
  logic [NUM-1:0]      hit;

  for (genvar i = 0; i < NUM; i++) begin : g_dec
    assign hit[i]       = wr_en && (addr == AW'(i));
    // Divider or source fields changing: restart that channel's counters.
    assign restart_o[i] = hit[i] && (wdata[7:1] != ctrl_q[i][7:1]);
  end

  always_comb begin
    ctrl_d = ctrl_q;
    for (int i = 0; i < NUM; i++) begin
      if (hit[i]) ctrl_d[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM; i++) begin
      if (addr == AW'(i)) rdata = ctrl_q[i];
    end
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/clkout_divstage.sv
module clkout_divstage #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          ev_i,
  input  logic [CW-1:0] lim_i,
  output logic          ev_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  assign wrap = (cnt_q >= lim_i);
  assign ev_o = ev_i && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (ev_i) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/clkout_chan.sv
module clkout_chan
  import clkout_pkg::*;
#(
  parameter int unsigned PRE_LAST = 122,
  parameter int          PRE_CW   = 7,
  parameter int          POST_CW  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ctrl_i,
  input  logic       restart_i,
  input  logic       ev_slow_i,
  input  logic       ev_fast_i,
  output logic       clk_o,
  output logic       run_o,
  output logic       tick_o
);

  logic              en;
  logic              src_fast;
  logic [2:0]        post_code;
  logic [2:0]        pre_code;
  logic [PRE_CW-1:0] pre_lim;
  logic [POST_CW-1:0] post_lim;
  logic              pre_ev;
  logic              mux_ev;
  logic              out_q, out_d;
  logic              run_q, run_d;

  assign en        = ctrl_i[0];
  assign post_code = ctrl_i[3:1];
  assign src_fast  = ctrl_i[4];
  assign pre_code  = ctrl_i[7:5];

  assign pre_lim  = PRE_CW'(pre_ratio(pre_code, PRE_LAST) - 1);
  assign post_lim = POST_CW'((32'd1 << post_code) - 1);

  clkout_divstage #(.CW(PRE_CW)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (restart_i),
    .ev_i  (ev_fast_i),
    .lim_i (pre_lim),
    .ev_o  (pre_ev)
  );

  // Event-level source selection: the pin is a register, so switching cannot glitch.
  assign mux_ev = src_fast ? pre_ev : ev_slow_i;

  clkout_divstage #(.CW(POST_CW)) u_post (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (restart_i),
    .ev_i  (mux_ev),
    .lim_i (post_lim),
    .ev_o  (tick_o)
  );

  // Gate: the enable is taken only while the output is low.
  always_comb begin
    run_d = run_q;
    if (!out_q) run_d = en;
    out_d = out_q ^ (tick_o && run_q && run_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      out_q <= out_d;
      run_q <= run_d;
    end
  end

  assign clk_o = out_q;
  assign run_o = run_q;

endmodule

// File: rtl/clkout_bank.sv
module clkout_bank #(
  parameter int          NUM_OUT     = 3,
  parameter int          ADDR_W      = 2,
  parameter int unsigned PRE_LAST    = 122,
  parameter int          SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic               ref_slow,
  input  logic               ref_fast,
  output logic [NUM_OUT-1:0] clk_out
);

  localparam int PRE_CW  = $clog2(PRE_LAST);
  localparam int POST_CW = (1 << 3) - 1;

  logic                      rst_n_s;
  logic                      ev_slow_w;
  logic                      ev_fast_w;
  logic [NUM_OUT-1:0][7:0]   ctrl_w;
  logic [NUM_OUT-1:0]        restart_w;
  logic [NUM_OUT-1:0]        run_w;
  logic [NUM_OUT-1:0]        tick_w;

  clkout_rstsync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  clkout_refsync #(.STAGES(SYNC_STAGES)) u_sync_slow (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ref_i  (ref_slow),
    .edge_o (ev_slow_w)
  );

  clkout_refsync #(.STAGES(SYNC_STAGES)) u_sync_fast (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ref_i  (ref_fast),
    .edge_o (ev_fast_w)
  );

  clkout_regs #(.NUM(NUM_OUT), .AW(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .ctrl_o    (ctrl_w),
    .restart_o (restart_w)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chan
    clkout_chan #(
      .PRE_LAST (PRE_LAST),
      .PRE_CW   (PRE_CW),
      .POST_CW  (POST_CW)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .ctrl_i    (ctrl_w[i]),
      .restart_i (restart_w[i]),
      .ev_slow_i (ev_slow_w),
      .ev_fast_i (ev_fast_w),
      .clk_o     (clk_out[i]),
      .run_o     (run_w[i]),
      .tick_o    (tick_w[i])
    );
  end

endmodule

// File: rtl/clkout_bank_chk.sv
module clkout_bank_chk #(
  parameter int NUM_OUT = 3,
  parameter int ADDR_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [NUM_OUT-1:0][7:0] ctrl,
  input logic [NUM_OUT-1:0]      clk_out,
  input logic [NUM_OUT-1:0]      run,
  input logic [NUM_OUT-1:0]      tick,
  input logic                    ev_slow
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] |-> !clk_out[i]); // R2

    AST_GATE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] != $past(run[i])) |-> !$past(clk_out[i])); // R9

    AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_out[i] != $past(clk_out[i])) |-> $past(tick[i])); // R8

    AST_SLOW_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && !ctrl[i][4]) |-> ev_slow); // R6

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(i)) |=> $stable(ctrl[i])); // R1
  end

endmodule

bind clkout_bank clkout_bank_chk #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .ctrl    (ctrl_w),
  .clk_out (clk_out),
  .run     (run_w),
  .tick    (tick_w),
  .ev_slow (ev_slow_w)
);

// File: tb/tb_clkout_bank.sv
module tb_clkout_bank;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       ref_slow;
  logic       ref_fast;
  logic [2:0] clk_out;

  int n_tests;
  int n_fail;
  bit done;

  clkout_bank dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .ref_slow (ref_slow),
    .ref_fast (ref_fast),
    .clk_out  (clk_out)
  );

  // 125 MHz core clock; references at 16 and 6 core periods, toggling 1 ns before a core edge.
  initial begin clk = 1'b0; forever #4 clk = ~clk; end
  initial begin ref_slow = 1'b0; #3; forever #64 ref_slow = ~ref_slow; end
  initial begin ref_fast = 1'b0; #3; forever #24 ref_fast = ~ref_fast; end

  // {channel, control byte, expected period in core cycles}
  localparam logic [25:0] VEC [9] = '{
    {2'd0, 8'h01, 16'd16},   // R2 R3 R4: slow, n=0
    {2'd1, 8'h05, 16'd64},   // R3: slow, n=2
    {2'd2, 8'h11, 16'd6},    // R4 R5: fast, ratio 1
    {2'd0, 8'h31, 16'd12},   // R5: fast, ratio 2
    {2'd1, 8'hF1, 16'd732},  // R5: fast, ratio 122
    {2'd2, 8'hE9, 16'd256},  // R6: slow, pre code 7 ignored, n=4
    {2'd0, 8'h93, 16'd192},  // R5 R3: ratio 16, n=1
    {2'd1, 8'h0F, 16'd2048}, // R3: slow, n=7
    {2'd2, 8'hD3, 16'd768}   // R5: ratio 64, n=1
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_rise(input int ch);
    logic p;
    p = clk_out[ch];
    while (1) begin
      @(negedge clk);
      if (!p && clk_out[ch]) break;
      p = clk_out[ch];
    end
  endtask

  task automatic measure(input int ch, output int per, output int hi);
    bit fell;
    wait_rise(ch);
    hi = 1; per = 0; fell = 0;
    while (1) begin
      @(negedge clk);
      per++;
      if (!clk_out[ch]) fell = 1;
      else if (!fell) hi++;
      else break;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int per, hi, cnt;
    n_tests = 0; n_fail = 0; done = 0;
    wr_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10: reset state
    for (int a = 0; a < 3; a++) begin
      reg_read(2'(a), rd);
      check(rd == 8'h00, "R10 reg reset", rd, 0);
    end
    cnt = 0;
    repeat (100) begin @(negedge clk); if (clk_out != 3'b000) cnt++; end
    check(cnt == 0, "R10 outputs low after reset", cnt, 0);

    // Vector table
    for (int v = 0; v < 9; v++) begin
      int ch;
      logic [7:0] c;
      int ep;
      ch = int'(VEC[v][25:24]);
      c  = VEC[v][23:16];
      ep = int'(VEC[v][15:0]);
      reg_write(2'(ch), c);
      reg_read(2'(ch), rd);
      check(rd == c, "R1 readback", rd, c);
      measure(ch, per, hi);
      check(per == ep, "R3/R4/R5/R6/R8 period", per, ep);
      check(hi == ep / 2, "R7 duty", hi, ep / 2);
    end

    // R1: address 3 is ignored
    reg_write(2'd3, 8'hFF);
    reg_read(2'd0, rd); check(rd == 8'h93, "R1 addr3 write ch0", rd, 8'h93);
    reg_read(2'd1, rd); check(rd == 8'h0F, "R1 addr3 write ch1", rd, 8'h0F);
    reg_read(2'd2, rd); check(rd == 8'hD3, "R1 addr3 write ch2", rd, 8'hD3);
    reg_read(2'd3, rd); check(rd == 8'h00, "R1 addr3 reads 0", rd, 0);

    // R9: disable in the middle of a high phase (slow, n=2 -> high 32 cycles)
    reg_write(2'd1, 8'h05);
    wait_rise(1);
    repeat (3) @(negedge clk);
    reg_write(2'd1, 8'h04);
    check(clk_out[1] == 1'b1, "R9 still high after disable", clk_out[1], 1);
    cnt = 6;
    while (1) begin
      @(negedge clk);
      if (clk_out[1]) cnt++; else break;
    end
    check(cnt == 32, "R9 high phase completes", cnt, 32);
    cnt = 0;
    repeat (300) begin @(negedge clk); if (clk_out[1]) cnt++; end
    check(cnt == 0, "R2 held low while disabled", cnt, 0);

    // R2: re-enable restarts output
    reg_write(2'd1, 8'h05);
    measure(1, per, hi);
    check(per == 64, "R2 re-enable period", per, 64);

    // R10: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(clk_out == 3'b000, "R10 outputs low in reset", clk_out, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int a = 0; a < 3; a++) begin
      reg_read(2'(a), rd);
      check(rd == 8'h00, "R10 reg cleared by reset", rd, 0);
    end

    finish_run();
  end

endmodule